// File: doc/BRIEF.md
# Configuration Access Request Engine

This block carries out a single configuration read or write on a downstream link for a host processor. Software fills in a set of registers: the transaction type code, a 64-bit target address, the write data and a byte-lane strobe. It then sets a start bit. The engine sends one request to the link partner and waits for a completion. When the completion arrives, or when no completion arrives within a programmable number of cycles, it records the result. It then drops the start bit and raises a flag in its interrupt status register.

Software builds the target address word itself. The bus number goes in bits [27:20], the device in [19:15], the function in [14:12] and the dword register offset in [11:2]. For a sub-dword write, software shifts the data left by eight times the byte offset and shifts a run of ones, one per byte, into the strobe by the same amount. Control bit 24 asks the link side to skip address-window translation for this request. An interrupt mask decides which status flags drive the interrupt line.

Top module: `cfgreq_engine`

## Requirements
- R1: After reset, the start, status, read-data, interrupt-status and interrupt-mask registers read 0. The timeout-limit register (offset 0x28) reads TMO_DEFAULT, which is 200000 by default. `irq` and `lk_req_valid` are 0.
- R2: Writing a value with bit 0 set to offset 0x1C while the engine is idle makes `lk_req_valid` high for exactly one cycle, the cycle after the write. In that cycle `lk_req_type` equals control bits [3:0], `lk_req_addr` equals {address-high (0x0C), address-low (0x08)}, and `lk_req_xlat_bypass` equals control bit 24. Offset 0x1C bit 0 reads 1 from the write until the request finishes.
- R3: Type codes 0x8 (type-0 read), 0x9 (type-1 read), 0xA (type-0 write) and 0xB (type-1 write) are non-posted. These wait for a response and set status bit 0 to 1 when they finish. Any other type code is posted: it finishes on the clock edge that ends the request cycle, with status bit 0 = 0 and code 0.
- R4: A non-posted request finishes on the edge where `lk_rsp_valid` is sampled high. On that edge start clears, status bits [9:7] take `lk_rsp_code` (0 success, 1 unsupported request, 2 configuration retry, 4 completer abort), and interrupt-status bit 0 (done) sets.
- R5: Read data (offset 0x18) takes `lk_rsp_rdata` only when a 0x8 or 0x9 request finishes with code 0. Otherwise it keeps its value.
- R6: `lk_req_strb` equals strobe register bits [3:0] (offset 0x14). In `lk_req_wdata`, every byte lane whose strobe bit is 0 is zero. The other lanes carry the write-data register (offset 0x10).
- R7: Address-low bits [1:0] always read as 0 and are driven as 0 on `lk_req_addr`.
- R8: A write to start while a request is outstanding is ignored. It issues no second request and does not extend the outstanding one.
- R9: A non-posted request with no response for timeout-limit cycles after entering the wait finishes anyway. It sets interrupt-status bit 1 (timeout), leaves status and read data unchanged, and clears start. A response that arrives later is ignored.
- R10: Interrupt-status bits clear when 1 is written to them at offset 0x20. `irq` is high when any status bit is set whose mask bit (offset 0x24, bits [1:0]) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| lk_req_valid | output | 1 | One-cycle request to the link partner |
| lk_req_type | output | 4 | Transaction type code |
| lk_req_addr | output | 64 | Target address |
| lk_req_wdata | output | 32 | Write data with unstrobed lanes zeroed |
| lk_req_strb | output | 4 | Byte-lane strobe |
| lk_req_xlat_bypass | output | 1 | Skip address-window translation |
| lk_rsp_valid | input | 1 | Completion from the partner |
| lk_rsp_code | input | 3 | Completion code |
| lk_rsp_rdata | input | 32 | Completion read data |
| irq | output | 1 | Interrupt request |

## Verification
The request appears in the cycle right after the edge that writes start, so the bench checks the link outputs at the falling edge that follows that write. A completion takes effect on the same edge that samples `lk_rsp_valid`. The bench raises the response at a falling edge, holds it for one cycle, and reads start, status, read data and interrupt status at the next falling edge. A posted request finishes one edge after the request cycle, and a timeout fires the limit number of edges after the wait begins. For these, the bench samples at safe points before and after that edge rather than on it. Register reads are combinational, so each read is taken between edges.

// File: rtl/cfgreq_pkg.sv
package cfgreq_pkg;
   localparam int REG_AW = 6;
   localparam int DATA_W = 32;
   localparam int BYTES  = DATA_W / 8;
   localparam int ISR_W  = 2;
   localparam int ISR_DONE = 0;
   localparam int ISR_TMO  = 1;

   localparam logic [REG_AW-1:0] OFS_CTRL  = 6'h00;
   localparam logic [REG_AW-1:0] OFS_STAT  = 6'h04;
   localparam logic [REG_AW-1:0] OFS_ALO   = 6'h08;
   localparam logic [REG_AW-1:0] OFS_AHI   = 6'h0C;
   localparam logic [REG_AW-1:0] OFS_WDAT  = 6'h10;
   localparam logic [REG_AW-1:0] OFS_STRB  = 6'h14;
   localparam logic [REG_AW-1:0] OFS_RDAT  = 6'h18;
   localparam logic [REG_AW-1:0] OFS_START = 6'h1C;
   localparam logic [REG_AW-1:0] OFS_ISR   = 6'h20;
   localparam logic [REG_AW-1:0] OFS_IMSK  = 6'h24;
   localparam logic [REG_AW-1:0] OFS_TMO   = 6'h28;

   localparam logic [3:0] TY_RD0 = 4'h8;
   localparam logic [3:0] TY_RD1 = 4'h9;
   localparam logic [3:0] TY_WR0 = 4'hA;
   localparam logic [3:0] TY_WR1 = 4'hB;

   localparam logic [2:0] CPL_OK = 3'd0;

   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_st_t;

   function automatic logic ty_is_read(input logic [3:0] t);
      return (t == TY_RD0) || (t == TY_RD1);
   endfunction

   function automatic logic ty_is_np(input logic [3:0] t);
      return (t == TY_RD0) || (t == TY_RD1) || (t == TY_WR0) || (t == TY_WR1);
   endfunction
endpackage

// File: rtl/cfgreq_wdog.sv
module cfgreq_wdog #(
   parameter int TMO_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [TMO_W-1:0] lim_i,
   output logic             expire_o
);
   logic [TMO_W-1:0] cnt_q;
   logic [TMO_W:0]   cnt_inc;

   assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
   assign expire_o = run_i && (cnt_inc >= {1'b0, lim_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else             cnt_q <= cnt_inc[TMO_W-1:0];
   end

   // R9: every wait window starts counting from zero
   a_r9_window_fresh: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_i) |-> (cnt_q == '0));
endmodule

// File: rtl/cfgreq_lanes.sv
module cfgreq_lanes #(
   parameter int BYTES   = 4,
   parameter bit MASK_EN = 1'b1
) (
   input  logic [BYTES*8-1:0] data_i,
   input  logic [BYTES-1:0]   strb_i,
   output logic [BYTES*8-1:0] data_o
);
   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      if (MASK_EN) begin : g_mask
         assign data_o[b*8 +: 8] = strb_i[b] ? data_i[b*8 +: 8] : 8'h00;
      end else begin : g_pass
         assign data_o[b*8 +: 8] = data_i[b*8 +: 8];
      end
   end
endmodule

// File: rtl/cfgreq_seq.sv
module cfgreq_seq
   import cfgreq_pkg::*;
#(
   parameter int TMO_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic [3:0]        type_i,
   input  logic [TMO_W-1:0]  tmo_lim_i,
   input  logic              rsp_valid_i,
   input  logic [2:0]        rsp_code_i,
   input  logic [DATA_W-1:0] rsp_rdata_i,
   output logic              busy_o,
   output logic              req_valid_o,
   output logic              done_set_o,
   output logic              tmo_set_o,
   output logic [31:0]       stat_o,
   output logic [DATA_W-1:0] rdat_o
);
   seq_st_t st_q, st_d;
   logic    np_q, rd_q;
   logic    stat_np_q;
   logic [2:0] stat_code_q;
   logic [DATA_W-1:0] rdat_q;
   logic    expire;

   cfgreq_wdog #(.TMO_W(TMO_W)) u_wdog (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (st_q == ST_WAIT),
      .lim_i    (tmo_lim_i),
      .expire_o (expire)
   );

   always_comb begin
      st_d       = st_q;
      done_set_o = 1'b0;
      tmo_set_o  = 1'b0;
      unique case (st_q)
         ST_IDLE:  if (launch_i) st_d = ST_ISSUE;
         ST_ISSUE: begin
            if (np_q) st_d = ST_WAIT;
            else begin
               st_d       = ST_IDLE;
               done_set_o = 1'b1;
            end
         end
         ST_WAIT: begin
            if (rsp_valid_i) begin
               st_d       = ST_IDLE;
               done_set_o = 1'b1;
            end else if (expire) begin
               st_d      = ST_IDLE;
               tmo_set_o = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         np_q        <= 1'b0;
         rd_q        <= 1'b0;
         stat_np_q   <= 1'b0;
         stat_code_q <= '0;
         rdat_q      <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && launch_i) begin
            np_q <= ty_is_np(type_i);
            rd_q <= ty_is_read(type_i);
         end
         if (done_set_o) begin
            stat_np_q   <= np_q;
            stat_code_q <= (st_q == ST_WAIT) ? rsp_code_i : CPL_OK;
         end
         if (st_q == ST_WAIT && rsp_valid_i && rd_q && rsp_code_i == CPL_OK)
            rdat_q <= rsp_rdata_i;
      end
   end

   assign busy_o      = (st_q != ST_IDLE);
   assign req_valid_o = (st_q == ST_ISSUE);
   assign stat_o      = {22'd0, stat_code_q, 6'd0, stat_np_q};
   assign rdat_o      = rdat_q;

   // R2: a request lasts exactly one cycle
   a_r2_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |=> !req_valid_o);
   // R8: a start write while busy never produces a request
   a_r8_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && launch_i) |=> !req_valid_o);
   // R3: a posted request is finished right after its request cycle
   a_r3_posted_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !np_q) |=> !busy_o);
   // R5: read data moves only on a successful response
   a_r5_rdat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdat_q) |-> $past(rsp_valid_i && rsp_code_i == CPL_OK));
endmodule

// File: rtl/cfgreq_regs.sv
module cfgreq_regs
   import cfgreq_pkg::*;
#(
   parameter int              TMO_W       = 32,
   parameter longint unsigned TMO_DEFAULT = 200000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              busy_i,
   input  logic [31:0]       stat_i,
   input  logic [DATA_W-1:0] rdat_i,
   input  logic              done_set_i,
   input  logic              tmo_set_i,
   output logic              launch_o,
   output logic [3:0]        type_o,
   output logic              bypass_o,
   output logic [63:0]       addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic [BYTES-1:0]  strb_o,
   output logic [TMO_W-1:0]  tmo_lim_o,
   output logic              irq_o
);
   logic [31:0]       ctrl_q, ahi_q;
   logic [29:0]       alo_q;
   logic [DATA_W-1:0] wdat_q;
   logic [BYTES-1:0]  strb_q;
   logic [ISR_W-1:0]  isr_q, imsk_q, isr_clr, isr_set;
   logic [TMO_W-1:0]  tmo_q;

   assign isr_clr = (reg_we && reg_addr == OFS_ISR) ? reg_wdata[ISR_W-1:0] : '0;
   always_comb begin
      isr_set           = '0;
      isr_set[ISR_DONE] = done_set_i;
      isr_set[ISR_TMO]  = tmo_set_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ahi_q  <= '0;
         alo_q  <= '0;
         wdat_q <= '0;
         strb_q <= '0;
         isr_q  <= '0;
         imsk_q <= '0;
         tmo_q  <= TMO_W'(TMO_DEFAULT);
      end else begin
         if (reg_we) begin
            unique case (reg_addr)
               OFS_CTRL: ctrl_q <= reg_wdata;
               OFS_ALO:  alo_q  <= reg_wdata[31:2];
               OFS_AHI:  ahi_q  <= reg_wdata;
               OFS_WDAT: wdat_q <= reg_wdata;
               OFS_STRB: strb_q <= reg_wdata[BYTES-1:0];
               OFS_IMSK: imsk_q <= reg_wdata[ISR_W-1:0];
               OFS_TMO:  tmo_q  <= reg_wdata[TMO_W-1:0];
               default: ;
            endcase
         end
         isr_q <= (isr_q & ~isr_clr) | isr_set;
      end
   end

   always_comb begin
      unique case (reg_addr)
         OFS_CTRL:  reg_rdata = ctrl_q;
         OFS_STAT:  reg_rdata = stat_i;
         OFS_ALO:   reg_rdata = {alo_q, 2'b00};
         OFS_AHI:   reg_rdata = ahi_q;
         OFS_WDAT:  reg_rdata = wdat_q;
         OFS_STRB:  reg_rdata = DATA_W'(strb_q);
         OFS_RDAT:  reg_rdata = rdat_i;
         OFS_START: reg_rdata = DATA_W'(busy_i);
         OFS_ISR:   reg_rdata = DATA_W'(isr_q);
         OFS_IMSK:  reg_rdata = DATA_W'(imsk_q);
         OFS_TMO:   reg_rdata = DATA_W'(tmo_q);
         default:   reg_rdata = '0;
      endcase
   end

   assign launch_o  = reg_we && (reg_addr == OFS_START) && reg_wdata[0];
   assign type_o    = ctrl_q[3:0];
   assign bypass_o  = ctrl_q[24];
   assign addr_o    = {ahi_q, alo_q, 2'b00};
   assign wdata_o   = wdat_q;
   assign strb_o    = strb_q;
   assign tmo_lim_o = tmo_q;
   assign irq_o     = |(isr_q & ~imsk_q);

   // R4: whenever start drops, a done or timeout flag stands
   a_r4_flag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_i) |-> (isr_q != '0));
endmodule

// File: rtl/cfgreq_engine.sv
module cfgreq_engine
   import cfgreq_pkg::*;
#(
   parameter int              TMO_W        = 32,
   parameter longint unsigned TMO_DEFAULT  = 200000,
   parameter bit              STRB_MASK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              lk_req_valid,
   output logic [3:0]        lk_req_type,
   output logic [63:0]       lk_req_addr,
   output logic [DATA_W-1:0] lk_req_wdata,
   output logic [BYTES-1:0]  lk_req_strb,
   output logic              lk_req_xlat_bypass,
   input  logic              lk_rsp_valid,
   input  logic [2:0]        lk_rsp_code,
   input  logic [DATA_W-1:0] lk_rsp_rdata,
   output logic              irq
);
   if (TMO_W < 2 || TMO_W > 32) begin : g_bad_tmo_w
      $error("TMO_W must lie in 2..32");
   end
   if (TMO_DEFAULT == 0 || TMO_DEFAULT > ((64'd1 << TMO_W) - 64'd1)) begin : g_bad_tmo_def
      $error("TMO_DEFAULT must be nonzero and fit in TMO_W bits");
   end

   logic              launch, busy, done_set, tmo_set;
   logic [3:0]        typ;
   logic [31:0]       stat;
   logic [DATA_W-1:0] rdat, wdat;
   logic [TMO_W-1:0]  tmo_lim;

   cfgreq_regs #(.TMO_W(TMO_W), .TMO_DEFAULT(TMO_DEFAULT)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .busy_i     (busy),
      .stat_i     (stat),
      .rdat_i     (rdat),
      .done_set_i (done_set),
      .tmo_set_i  (tmo_set),
      .launch_o   (launch),
      .type_o     (typ),
      .bypass_o   (lk_req_xlat_bypass),
      .addr_o     (lk_req_addr),
      .wdata_o    (wdat),
      .strb_o     (lk_req_strb),
      .tmo_lim_o  (tmo_lim),
      .irq_o      (irq)
   );

   cfgreq_seq #(.TMO_W(TMO_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch_i    (launch),
      .type_i      (typ),
      .tmo_lim_i   (tmo_lim),
      .rsp_valid_i (lk_rsp_valid),
      .rsp_code_i  (lk_rsp_code),
      .rsp_rdata_i (lk_rsp_rdata),
      .busy_o      (busy),
      .req_valid_o (lk_req_valid),
      .done_set_o  (done_set),
      .tmo_set_o   (tmo_set),
      .stat_o      (stat),
      .rdat_o      (rdat)
   );

   cfgreq_lanes #(.BYTES(BYTES), .MASK_EN(STRB_MASK_EN)) u_lanes (
      .data_i (wdat),
      .strb_i (lk_req_strb),
      .data_o (lk_req_wdata)
   );

   assign lk_req_type = typ;
endmodule

// File: tb/tb_cfgreq_engine.sv
module tb_cfgreq_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lk_req_valid;
   logic [3:0]  lk_req_type;
   logic [63:0] lk_req_addr;
   logic [31:0] lk_req_wdata;
   logic [3:0]  lk_req_strb;
   logic        lk_req_xlat_bypass;
   logic        lk_rsp_valid = 1'b0;
   logic [2:0]  lk_rsp_code = '0;
   logic [31:0] lk_rsp_rdata = '0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   int req_cnt = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cfgreq_engine dut (.*);

   always @(negedge clk) if (lk_req_valid) req_cnt++;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic resp(input logic [2:0] code, input logic [31:0] data, input int dly);
      repeat (dly) @(negedge clk);
      lk_rsp_valid = 1'b1; lk_rsp_code = code; lk_rsp_rdata = data;
      @(negedge clk);
      lk_rsp_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(6'h1C, v); chk("R1 start", v, 0);
      rd(6'h04, v); chk("R1 status", v, 0);
      rd(6'h18, v); chk("R1 rdata", v, 0);
      rd(6'h20, v); chk("R1 isr", v, 0);
      rd(6'h24, v); chk("R1 mask", v, 0);
      rd(6'h28, v); chk("R1 tmo", v, 200000);
      chk("R1 irq", irq, 0);
      chk("R1 req", lk_req_valid, 0);
   endtask

   task automatic t_read_ok();
      logic [31:0] v;
      wr(6'h00, 32'h0100_0008);
      wr(6'h08, 32'h0032_A043);
      wr(6'h0C, 32'h0000_0001);
      rd(6'h08, v); chk("R7 alo readback", v, 32'h0032_A040);
      wr(6'h1C, 1);
      chk("R2 req valid", lk_req_valid, 1);
      chk("R2 type", lk_req_type, 4'h8);
      chk("R2 R7 addr", lk_req_addr, 64'h0000_0001_0032_A040);
      chk("R2 bypass", lk_req_xlat_bypass, 1);
      rd(6'h1C, v); chk("R2 start busy", v, 1);
      @(negedge clk);
      chk("R2 pulse ends", lk_req_valid, 0);
      resp(3'd0, 32'hCAFE_F00D, 2);
      rd(6'h1C, v); chk("R4 start clear", v, 0);
      rd(6'h04, v); chk("R3 R4 status ok", v, 32'h1);
      rd(6'h18, v); chk("R5 rdata", v, 32'hCAFE_F00D);
      rd(6'h20, v); chk("R4 done", v, 1);
      chk("R10 irq", irq, 1);
      wr(6'h20, 1);
      rd(6'h20, v); chk("R10 w1c", v, 0);
   endtask

   task automatic t_read_ur();
      logic [31:0] v;
      wr(6'h00, 32'h0000_0009);
      wr(6'h1C, 1);
      chk("R2 type1 rd", lk_req_type, 4'h9);
      chk("R2 no bypass", lk_req_xlat_bypass, 0);
      resp(3'd1, 32'h1234_5678, 1);
      rd(6'h04, v); chk("R4 status UR", v, 32'h81);
      rd(6'h18, v); chk("R5 rdata held on UR", v, 32'hCAFE_F00D);
      wr(6'h20, 1);
   endtask

   task automatic t_write_crs();
      logic [31:0] v;
      wr(6'h00, 32'h0000_000A);
      wr(6'h10, 32'hFFAB_55EE);
      wr(6'h14, 32'h0000_0004);
      wr(6'h1C, 1);
      chk("R6 strb", lk_req_strb, 4'h4);
      chk("R6 lane mask", lk_req_wdata, 32'h00AB_0000);
      resp(3'd2, 32'hDEAD_BEEF, 3);
      rd(6'h04, v); chk("R4 status CRS", v, 32'h101);
      rd(6'h18, v); chk("R5 rdata held on write", v, 32'hCAFE_F00D);
      wr(6'h20, 1);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      int base;
      wr(6'h00, 32'h0000_000B);
      wr(6'h14, 32'h0000_000F);
      base = req_cnt;
      wr(6'h1C, 1);
      chk("R6 full lanes", lk_req_wdata, 32'hFFAB_55EE);
      wr(6'h1C, 1);
      rd(6'h1C, v); chk("R8 still busy", v, 1);
      resp(3'd4, 32'h0, 0);
      rd(6'h1C, v); chk("R8 single finish", v, 0);
      rd(6'h04, v); chk("R4 status CA", v, 32'h201);
      repeat (3) @(negedge clk);
      chk("R8 one request", req_cnt - base, 1);
      wr(6'h20, 1);
   endtask

   task automatic t_posted();
      logic [31:0] v;
      wr(6'h00, 32'h0000_0000);
      wr(6'h1C, 1);
      chk("R3 posted req", lk_req_valid, 1);
      @(negedge clk);
      rd(6'h1C, v); chk("R3 posted done fast", v, 0);
      rd(6'h04, v); chk("R3 posted status", v, 0);
      rd(6'h20, v); chk("R3 posted done flag", v, 1);
      wr(6'h20, 1);
   endtask

   task automatic t_timeout();
      logic [31:0] v;
      wr(6'h28, 20);
      wr(6'h00, 32'h0000_0009);
      wr(6'h1C, 1);
      repeat (10) @(negedge clk);
      rd(6'h1C, v); chk("R9 waiting", v, 1);
      repeat (15) @(negedge clk);
      rd(6'h1C, v); chk("R9 start clear", v, 0);
      rd(6'h20, v); chk("R9 tmo flag", v, 2);
      rd(6'h04, v); chk("R9 status kept", v, 0);
      resp(3'd0, 32'h5555_AAAA, 1);
      rd(6'h18, v); chk("R9 late rsp ignored", v, 32'hCAFE_F00D);
      rd(6'h20, v); chk("R9 no done on late rsp", v, 2);
      chk("R10 irq tmo", irq, 1);
      wr(6'h24, 2);
      chk("R10 masked", irq, 0);
      wr(6'h20, 2);
      rd(6'h20, v); chk("R10 w1c tmo", v, 0);
      wr(6'h24, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_read_ok();
      t_read_ur();
      t_write_crs();
      t_busy_ignore();
      t_posted();
      t_timeout();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule